// File: doc/BRIEF.md
# VPW Frame Transmitter

This block turns a message held in a small byte buffer into a variable-pulse-width waveform on a single transmit line. The line feeds a bus transceiver. Software or a controller first writes the message bytes through a byte-wide write port, one address per byte. It then pulses `start` with the byte count. The block plays out a long high start symbol and then every bit of the message, most significant bit first. It appends a CRC byte it computes itself, holds the line low for the end-of-frame period, and finally enforces a quiet separation time before it accepts another frame.

Bits are coded by duration, not by fixed cells. The line level flips after every bit, and whether a bit takes a short or a long symbol depends on its value and the level it sits on. A fast mode, sampled at `start`, divides every symbol duration by four. All timing derives from a microsecond tick produced by a prescaler of `CLK_PER_US` clocks.

Top module: `vpw_frame_tx`

## Requirements
- R1: After reset `tx`, `busy`, `done` and `rejected` are all low.
- R2: A `start` seen while idle with `start_len` from 1 to MAX_FRAME_BYTES-1 (1..11 by default) is accepted. In the next cycle `busy` and `tx` are high, and `tx` stays high for the start symbol of 200 µs (200*CLK_PER_US clocks).
- R3: A `start` seen while idle with `start_len` of 0 or above MAX_FRAME_BYTES-1 is refused. `rejected` is high for exactly one cycle, and `busy` and `tx` stay low. No frame ever carries more than MAX_FRAME_BYTES bytes including the CRC.
- R4: After the start symbol, the bytes at buffer addresses 0..start_len-1 are sent in order, each most significant bit first. The first bit sits on the low level and the levels alternate afterwards. A bit equal to its level (1 on high, 0 on low) lasts 64 µs. Any other bit lasts 128 µs.
- R5: After the data, one extra byte is sent with the same bit coding. Its value is the bitwise complement of a CRC-8 with polynomial 0x1D (x^8+x^4+x^3+x^2+1) and preset 0xFF, shifted over the data bits most significant bit first. The start symbol does not enter the CRC.
- R6: After the last CRC bit, `tx` is low for 280 µs and then `busy` falls. `done` is high for exactly the one cycle in which `busy` is first low.
- R7: When `fast_mode` is high in the accepting cycle, every symbol duration and the separation time are a quarter of normal. `fast_mode` is ignored at all other times.
- R8: For 300 µs (75 µs in fast mode) after `done`, `start` has no effect: no `busy`, no `rejected`. It is honoured in the very next cycle.
- R9: A `start` presented while a frame is in progress has no effect. The running frame keeps its timing and `rejected` stays low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| ld_we | input | 1 | Write one message byte |
| ld_addr | input | clog2(MAX_FRAME_BYTES-1) | Byte position in the message |
| ld_data | input | 8 | Byte value |
| start | input | 1 | Request to send a frame |
| start_len | input | clog2(MAX_FRAME_BYTES+1) | Number of data bytes |
| fast_mode | input | 1 | Quarter-duration symbols for this frame |
| busy | output | 1 | Frame in progress, start symbol through end-of-frame |
| done | output | 1 | One-cycle pulse after end-of-frame |
| rejected | output | 1 | One-cycle pulse for a refused length |
| tx | output | 1 | Serial line to the transceiver |

## Verification
The hardest situation to reach is the exact cycle where the inter-frame separation ends. A `start` one cycle early must vanish, and one cycle later it must launch a frame. The bench chains every frame to the next by counting clocks from the `done` pulse. It loads the next message inside the separation window and raises `start` precisely on the last ignored cycle, holding it one more cycle. Frames of every legal length in fast mode, with `start` also held high throughout one frame and `fast_mode` flipped after acceptance, cover the sampling rules.

// File: rtl/vpw_tx_pkg.sv
package vpw_tx_pkg;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_SOF,
    ST_BITS,
    ST_EOF,
    ST_IFS
  } vpw_state_e;

  localparam logic [7:0] CRC_POLY   = 8'h1D;
  localparam logic [7:0] CRC_PRESET = 8'hFF;

endpackage

// File: rtl/vpw_sym_timer.sv
module vpw_sym_timer #(
  parameter int CLK_PER_US = 50,
  parameter int US_W       = 10
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            run,
  input  logic [US_W-1:0] dur_us,
  output logic            expire
);
  localparam int PRE_W = (CLK_PER_US > 1) ? $clog2(CLK_PER_US) : 1;

  logic [PRE_W-1:0] pre_q;
  logic [US_W-1:0]  us_q;
  logic             tick;

  assign tick   = (pre_q == PRE_W'(CLK_PER_US - 1));
  assign expire = run && tick && (us_q == dur_us - 1'b1);

  always_ff @(posedge clk) begin
    if (rst || !run) begin
      pre_q <= '0;
      us_q  <= '0;
    end else if (tick) begin
      pre_q <= '0;
      us_q  <= expire ? '0 : us_q + 1'b1;
    end else begin
      pre_q <= pre_q + 1'b1;
    end
  end

  // R4: the microsecond count never passes the requested symbol length
  p_us_in_window_r4: assert property (@(posedge clk) disable iff (rst)
    run |-> (us_q < dur_us));

endmodule

// File: rtl/vpw_crc8.sv
module vpw_crc8
  import vpw_tx_pkg::*;
(
  input  logic       clk,
  input  logic       rst,
  input  logic       clear,
  input  logic       shift_en,
  input  logic       bit_i,
  output logic [7:0] crc_next
);
  logic [7:0] crc_q;

  assign crc_next = {crc_q[6:0], 1'b0} ^ ((crc_q[7] ^ bit_i) ? CRC_POLY : 8'h00);

  always_ff @(posedge clk) begin
    if (rst || clear) crc_q <= CRC_PRESET;
    else if (shift_en) crc_q <= crc_next;
  end

  // R5: the register only moves while data bits are being shifted
  p_crc_hold_r5: assert property (@(posedge clk) disable iff (rst)
    (!$past(shift_en) && !$past(clear)) |-> $stable(crc_q));

endmodule

// File: rtl/vpw_msg_buf.sv
module vpw_msg_buf #(
  parameter int DEPTH = 11,
  parameter int AW    = 4,
  parameter int RW    = 4
) (
  input  logic          clk,
  input  logic          we,
  input  logic [AW-1:0] waddr,
  input  logic [7:0]    wdata,
  input  logic [RW-1:0] raddr,
  output logic [7:0]    rdata
);
  logic [7:0] mem [DEPTH];

  always_ff @(posedge clk) begin
    if (we && (32'(waddr) < DEPTH)) mem[waddr] <= wdata;
    if (32'(raddr) < DEPTH) rdata <= mem[raddr[AW-1:0]];
  end

endmodule

// File: rtl/vpw_frame_tx.sv
module vpw_frame_tx
  import vpw_tx_pkg::*;
#(
  parameter int CLK_PER_US      = 50,
  parameter int MAX_FRAME_BYTES = 12,
  parameter int SOF_US          = 200,
  parameter int SHORT_US        = 64,
  parameter int LONG_US         = 128,
  parameter int EOF_US          = 280,
  parameter int IFS_US          = 300
) (
  input  logic                                   clk,
  input  logic                                   rst,
  input  logic                                   ld_we,
  input  logic [$clog2(MAX_FRAME_BYTES-1)-1:0]   ld_addr,
  input  logic [7:0]                             ld_data,
  input  logic                                   start,
  input  logic [$clog2(MAX_FRAME_BYTES+1)-1:0]   start_len,
  input  logic                                   fast_mode,
  output logic                                   busy,
  output logic                                   done,
  output logic                                   rejected,
  output logic                                   tx
);
  localparam int DATA_MAX = MAX_FRAME_BYTES - 1;
  localparam int AW       = $clog2(DATA_MAX);
  localparam int LEN_W    = $clog2(MAX_FRAME_BYTES + 1);
  localparam int US_W     = $clog2(SOF_US + LONG_US + EOF_US + IFS_US + 1);

  vpw_state_e       st_q;
  logic             tx_q, busy_q, done_q, rej_q;
  logic             lvl_q, crc_ph_q, fast_q;
  logic [7:0]       sh_q;
  logic [2:0]       bit_q;
  logic [LEN_W-1:0] byte_idx_q, len_q;
  logic [7:0]       rd_byte, crc_nx;
  logic [US_W-1:0]  raw_us, dur_us;
  logic             sym_end, len_ok, accept, run;

  assign len_ok = (start_len != '0) && (start_len <= LEN_W'(DATA_MAX));
  assign accept = (st_q == ST_IDLE) && start && len_ok;
  assign run    = (st_q != ST_IDLE);

  always_comb begin
    unique case (st_q)
      ST_SOF:  raw_us = US_W'(SOF_US);
      ST_BITS: raw_us = (sh_q[7] == lvl_q) ? US_W'(SHORT_US) : US_W'(LONG_US);
      ST_EOF:  raw_us = US_W'(EOF_US);
      ST_IFS:  raw_us = US_W'(IFS_US);
      default: raw_us = US_W'(SOF_US);
    endcase
    dur_us = fast_q ? (raw_us >> 2) : raw_us;
  end

  vpw_sym_timer #(.CLK_PER_US(CLK_PER_US), .US_W(US_W)) timer_i (
    .clk(clk), .rst(rst), .run(run), .dur_us(dur_us), .expire(sym_end)
  );

  vpw_crc8 crc_i (
    .clk(clk), .rst(rst),
    .clear(st_q == ST_IDLE),
    .shift_en((st_q == ST_BITS) && sym_end && !crc_ph_q),
    .bit_i(sh_q[7]),
    .crc_next(crc_nx)
  );

  vpw_msg_buf #(.DEPTH(DATA_MAX), .AW(AW), .RW(LEN_W)) buf_i (
    .clk(clk), .we(ld_we), .waddr(ld_addr), .wdata(ld_data),
    .raddr(byte_idx_q), .rdata(rd_byte)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      st_q       <= ST_IDLE;
      tx_q       <= 1'b0;
      busy_q     <= 1'b0;
      done_q     <= 1'b0;
      rej_q      <= 1'b0;
      lvl_q      <= 1'b0;
      crc_ph_q   <= 1'b0;
      fast_q     <= 1'b0;
      sh_q       <= '0;
      bit_q      <= '0;
      byte_idx_q <= '0;
      len_q      <= '0;
    end else begin
      done_q <= 1'b0;
      rej_q  <= 1'b0;
      unique case (st_q)
        ST_IDLE: begin
          if (start) begin
            if (len_ok) begin
              st_q       <= ST_SOF;
              busy_q     <= 1'b1;
              tx_q       <= 1'b1;
              fast_q     <= fast_mode;
              len_q      <= start_len;
              byte_idx_q <= '0;
              crc_ph_q   <= 1'b0;
            end else begin
              rej_q <= 1'b1;
            end
          end
        end
        ST_SOF: begin
          if (sym_end) begin
            st_q       <= ST_BITS;
            tx_q       <= 1'b0;
            lvl_q      <= 1'b0;
            sh_q       <= rd_byte;
            bit_q      <= '0;
            byte_idx_q <= byte_idx_q + 1'b1;
          end
        end
        ST_BITS: begin
          if (sym_end) begin
            lvl_q <= ~lvl_q;
            tx_q  <= ~lvl_q;
            bit_q <= bit_q + 1'b1;
            if (bit_q == 3'd7) begin
              if (!crc_ph_q && (byte_idx_q < len_q)) begin
                sh_q       <= rd_byte;
                byte_idx_q <= byte_idx_q + 1'b1;
              end else if (!crc_ph_q) begin
                sh_q     <= ~crc_nx;
                crc_ph_q <= 1'b1;
              end else begin
                st_q <= ST_EOF;
                tx_q <= 1'b0;
              end
            end else begin
              sh_q <= {sh_q[6:0], 1'b0};
            end
          end
        end
        ST_EOF: begin
          if (sym_end) begin
            st_q   <= ST_IFS;
            busy_q <= 1'b0;
            done_q <= 1'b1;
          end
        end
        ST_IFS: begin
          if (sym_end) st_q <= ST_IDLE;
        end
        default: st_q <= ST_IDLE;
      endcase
    end
  end

  assign busy     = busy_q;
  assign done     = done_q;
  assign rejected = rej_q;
  assign tx       = tx_q;

  // R6: the line rests low whenever no frame is active
  p_idle_low_r6: assert property (@(posedge clk) disable iff (rst)
    !busy_q |-> !tx_q);

  // R6: done follows the fall of busy and lasts one cycle
  p_done_after_busy_r6: assert property (@(posedge clk) disable iff (rst)
    done_q |-> (!busy_q && $past(busy_q)));
  p_done_single_r6: assert property (@(posedge clk) disable iff (rst)
    done_q |=> !done_q);

  // R3: a refused request leaves the line and busy untouched
  p_reject_quiet_r3: assert property (@(posedge clk) disable iff (rst)
    rej_q |-> (!busy_q && !tx_q));

  // R3: never more data bytes than were requested, never above the cap
  p_byte_cap_r3: assert property (@(posedge clk) disable iff (rst)
    run |-> ((byte_idx_q <= len_q) && (len_q <= LEN_W'(DATA_MAX))));

  // R4: the line only changes at an accepted start or a symbol boundary
  p_tx_edges_r4: assert property (@(posedge clk) disable iff (rst)
    !$stable(tx_q) |-> ($past(sym_end) || $past(accept)));

  // R7: the speed choice is frozen for the whole frame
  p_fast_frozen_r7: assert property (@(posedge clk) disable iff (rst)
    (busy_q && $past(busy_q)) |-> $stable(fast_q));

  // R8: separation time never raises busy or a refusal
  p_ifs_quiet_r8: assert property (@(posedge clk) disable iff (rst)
    (st_q == ST_IFS) |=> (!busy_q && !rej_q));

endmodule

// File: tb/vpw_frame_tx_tb_top.sv
module vpw_frame_tx_tb_top;
  localparam int CPU   = 2;
  localparam int MAXB  = 12;
  localparam int LIMIT = 190000;

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       ld_we = 1'b0;
  logic [3:0] ld_addr = '0;
  logic [7:0] ld_data = '0;
  logic       start = 1'b0;
  logic [3:0] start_len = '0;
  logic       fast_mode = 1'b0;
  logic       busy, done, rejected, tx;

  int vectors = 0;
  int fails   = 0;
  int cyc     = 0;
  bit rej_seen = 0;
  logic [7:0] msg [16];

  always #5 clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  vpw_frame_tx #(.CLK_PER_US(CPU), .MAX_FRAME_BYTES(MAXB)) dut_i (
    .clk(clk), .rst(rst), .ld_we(ld_we), .ld_addr(ld_addr), .ld_data(ld_data),
    .start(start), .start_len(start_len), .fast_mode(fast_mode),
    .busy(busy), .done(done), .rejected(rejected), .tx(tx)
  );

  task automatic check(input bit ok, input string req, input int act, input int exp);
    vectors++;
    if (!ok) begin
      fails++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  function automatic int dclk(input int us, input bit fast);
    return (fast ? us / 4 : us) * CPU;
  endfunction

  function automatic logic [7:0] pat(input int idx, input int i);
    if (idx == 12) return 8'h00;
    if (idx == 13) return 8'hFF;
    return 8'((idx * 53 + i * 29 + 7) & 255);
  endfunction

  function automatic logic [7:0] crc_ref(input int n);
    logic [7:0] c = 8'hFF;
    for (int i = 0; i < n; i++)
      for (int b = 7; b >= 0; b--) begin
        logic fb = c[7] ^ msg[i][b];
        c = {c[6:0], 1'b0};
        if (fb) c = c ^ 8'h1D;
      end
    return ~c;
  endfunction

  task automatic load_msg(input int n, input int idx);
    for (int i = 0; i < n; i++) begin
      msg[i]  = pat(idx, i);
      ld_we   = 1'b1;
      ld_addr = 4'(i);
      ld_data = msg[i];
      @(negedge clk);
    end
    ld_we = 1'b0;
  endtask

  task automatic measure(input logic level, output int cnt);
    cnt = 0;
    while (tx == level && busy && cyc < LIMIT) begin
      cnt++;
      @(negedge clk);
      if (rejected) rej_seen = 1;
    end
  endtask

  // entered at the negedge right after the accepting edge
  task automatic frame_body(input int n, input bit fast, input bit hold);
    int cnt;
    logic [7:0] crc = crc_ref(n);
    rej_seen = 0;
    check(busy === 1'b1 && tx === 1'b1, "R2 accept", int'({busy, tx}), 3);
    if (hold) begin
      start = 1'b1;
      start_len = 4'd0;
    end
    measure(1'b1, cnt);
    check(cnt == dclk(200, fast), "R2/R7 start symbol", cnt, dclk(200, fast));
    for (int b = 0; b < 8 * (n + 1); b++) begin
      logic [7:0] byt = (b / 8 < n) ? msg[b / 8] : crc;
      logic bv = byt[7 - b % 8];
      logic lv = logic'(b % 2);
      int exp = dclk((bv == lv) ? 64 : 128, fast);
      measure(lv, cnt);
      check(cnt == exp, (b / 8 < n) ? "R4/R7 data bit" : "R5 crc bit", cnt, exp);
    end
    measure(1'b0, cnt);
    check(cnt == dclk(280, fast), "R6 end of frame", cnt, dclk(280, fast));
    check(done === 1'b1 && busy === 1'b0 && tx === 1'b0, "R6 done pulse",
          int'({done, busy, tx}), 4);
    if (hold) begin
      start = 1'b0;
      check(rej_seen == 0, "R9 start during frame", int'(rej_seen), 0);
    end
  endtask

  // entered at the negedge where done is high
  task automatic ifs_chain(input bit prev_fast, input int n, input bit fast, input int idx);
    int ifs = dclk(300, prev_fast);
    start = 1'b1;
    start_len = 4'(n);
    @(negedge clk);
    start = 1'b0;
    check(done === 1'b0, "R6 done width", int'(done), 0);
    check(busy === 1'b0 && rejected === 1'b0, "R8 early start", int'({busy, rejected}), 0);
    load_msg(n, idx);
    repeat (ifs - 2 - n) @(negedge clk);
    start = 1'b1;
    start_len = 4'(n);
    fast_mode = fast;
    @(negedge clk);
    check(busy === 1'b0 && rejected === 1'b0, "R8 last quiet cycle", int'({busy, rejected}), 0);
    @(negedge clk);
    start = 1'b0;
    fast_mode = ~fast;
  endtask

  task automatic try_reject(input int len);
    start = 1'b1;
    start_len = 4'(len);
    @(negedge clk);
    start = 1'b0;
    check(rejected === 1'b1 && busy === 1'b0 && tx === 1'b0, "R3 refuse",
          int'({rejected, busy, tx}), 4);
    @(negedge clk);
    check(rejected === 1'b0 && busy === 1'b0, "R3 refuse width", int'({rejected, busy}), 0);
  endtask

  initial begin
    repeat (LIMIT) @(posedge clk);
    fails++;
    $display("FAIL watchdog: actual %0d expected %0d", LIMIT, 0);
    $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
    $finish;
  end

  initial begin
    int lens  [14];
    bit fasts [14];
    bit holds [14];
    for (int k = 0; k < 11; k++) begin
      lens[k] = k + 1; fasts[k] = 1'b1; holds[k] = (k == 5);
    end
    lens[11] = 1;  fasts[11] = 1'b0; holds[11] = 1'b0;
    lens[12] = 11; fasts[12] = 1'b0; holds[12] = 1'b1;
    lens[13] = 5;  fasts[13] = 1'b1; holds[13] = 1'b0;

    repeat (3) @(negedge clk);
    check(tx === 1'b0 && busy === 1'b0 && done === 1'b0 && rejected === 1'b0,
          "R1 in reset", int'({tx, busy, done, rejected}), 0);
    rst = 1'b0;
    @(negedge clk);
    check(tx === 1'b0 && busy === 1'b0 && done === 1'b0 && rejected === 1'b0,
          "R1 after reset", int'({tx, busy, done, rejected}), 0);

    try_reject(0);
    try_reject(12);
    try_reject(15);

    load_msg(lens[0], 0);
    start = 1'b1;
    start_len = 4'(lens[0]);
    fast_mode = fasts[0];
    @(negedge clk);
    start = 1'b0;
    fast_mode = ~fasts[0];
    frame_body(lens[0], fasts[0], holds[0]);
    for (int k = 1; k < 14; k++) begin
      ifs_chain(fasts[k - 1], lens[k], fasts[k], k);
      frame_body(lens[k], fasts[k], holds[k]);
    end

    @(negedge clk);
    check(done === 1'b0 && busy === 1'b0, "R6 final done width", int'({done, busy}), 0);
    $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
    $finish;
  end

endmodule